// File: doc/BRIEF.md
# Parallel FPGA Configuration Loader

This block sits on the host side of a board and writes a configuration bitstream into a target FPGA through its byte-wide slave parallel port. A one-cycle start pulse begins a load. The block first pulses the target's active-low program pin and waits for the target to pull its init pin low. It then releases program and waits for init to come back high. Next it enables the port by asserting write and then chip-select, and it lets the port settle before any data goes out.

Bytes come from a valid/ready stream, and a byte count given at start sets the length of the load. Each byte is placed on the data bus and strobed in with one low-then-high period of the configuration clock. Before each byte the block looks at the target's done and init pins. Done ends the load early. Init going low during the data phase is a configuration error. An optional busy wait follows every byte. After the data, the block releases the port and waits for done high with init high.

Every waiting phase has its own cycle-count timeout, set by a parameter. Any failure releases the port and returns the block to idle with a cause code. The number of bytes written is always visible, so a mid-load error shows where the load stopped.

Top module: `cfg_loader`

## Requirements
- R1: After reset, prog_no, cs_no and wr_no are high; cclk_o, ready_o, run_o and ok_o are low; err_o is 0.
- R2: A start_i pulse in idle drives prog_no low. prog_no stays low for at least PROG_CYC cycles and until init_ni has been sampled low. It is then released after exactly max(PROG_CYC, cycles until init low is first sampled) cycles.
- R3: If init_ni has not been sampled low by the INIT_TO-th cycle of the program pulse, the load aborts with err_o = 1.
- R4: When program is released, cclk_o goes high. If init_ni is still low on the INIT_TO-th cycle after release, the load aborts with err_o = 2.
- R5: Once init_ni is sampled high, wr_no goes low. cs_no goes low one cycle later. ready_o first rises SETTLE_CYC cycles after cs_no falls.
- R6: A byte accepted with ready_o and valid_i appears on data_o in the next cycle, with cclk_o low. cclk_o returns high in the cycle after that. Bytes reach the target in stream order, and no more than total_i bytes are ever written.
- R7: ready_o is high only in the data phase, with cs_no and wr_no low and cclk_o high.
- R8: When done_i is high before a byte, no further byte is written and the completion check begins. sent_o then holds the number of bytes already written.
- R9: When init_ni is low before a byte (and done_i is low), the load aborts with err_o = 3. sent_o holds the number of bytes written.
- R10: With BUSY_CHK set, each byte is followed by a wait for busy_i low. If busy_i is still high on the BUSY_TO-th cycle, the load aborts with err_o = 4.
- R11: At the normal end of the data phase, cs_no rises one cycle before wr_no.
- R12: If done_i is high and init_ni high within DONE_TO cycles after wr_no rises, ok_o is set and err_o stays 0. Otherwise the load aborts with err_o = 5. ok_o and a non-zero err_o are never set together.
- R13: On any abort, and whenever the block is idle, prog_no, cs_no and wr_no are high and run_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that starts a load when idle |
| total_i | input | CNT_W | Number of bytes to load, sampled at start |
| valid_i | input | 1 | Stream byte valid |
| byte_i | input | 8 | Stream byte |
| ready_o | output | 1 | Stream ready (data phase only) |
| run_o | output | 1 | Load in progress |
| ok_o | output | 1 | Last load completed successfully |
| err_o | output | 3 | Cause of last abort: 0 none, 1 init-assert timeout, 2 init-release timeout, 3 mid-load init error, 4 busy timeout, 5 done timeout |
| sent_o | output | CNT_W | Bytes written in the current or last load |
| prog_no | output | 1 | Target program, active low |
| init_ni | input | 1 | Target init, active low |
| busy_i | input | 1 | Target busy, active high |
| done_i | input | 1 | Target done, active high |
| cs_no | output | 1 | Target chip-select, active low |
| wr_no | output | 1 | Target write strobe, active low |
| cclk_o | output | 1 | Configuration clock to target |
| data_o | output | 8 | Configuration data bus |

## Verification
The hardest cases to reach are the exact timeout boundaries, where a target response one cycle later turns a pass into an abort. The same applies to the interaction between the per-byte done, init and busy checks and the byte count. A behavioural target model in the bench reacts to the loader's pins with per-load delays: cycles to pull init low, cycles to release it, the byte after which it reports a CRC-style error or an early done, busy length per byte, and completion delay. Directed loads set each delay to its limit and one past it. Random loads draw all delays and stream gaps, and a bench function predicts the outcome code, the byte count and the program pulse width.

// File: rtl/cfg_ld_pkg.sv
package cfg_ld_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PROG,
    ST_REL,
    ST_WREN,
    ST_SETTLE,
    ST_DATA,
    ST_HI,
    ST_BWAIT,
    ST_FIN,
    ST_CHK
  } ld_st_e;

  localparam logic [2:0] ERR_NONE     = 3'd0;
  localparam logic [2:0] ERR_INIT_SET = 3'd1;
  localparam logic [2:0] ERR_INIT_REL = 3'd2;
  localparam logic [2:0] ERR_MIDLOAD  = 3'd3;
  localparam logic [2:0] ERR_BUSY     = 3'd4;
  localparam logic [2:0] ERR_DONE     = 3'd5;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cfg_ld_timer.sv
module cfg_ld_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          q_q <= '0;
    else if (clr_i)       q_q <= '0;
    else if (q_q != '1)   q_q <= q_q + 1'b1;
  end

  assign q_o = q_q;

endmodule

// File: rtl/cfg_ld_bytecnt.sv
module cfg_ld_bytecnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  input  logic [W-1:0] limit_i,
  output logic [W-1:0] q_o,
  output logic         last_o
);

  logic [W-1:0] cnt_q, lim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
      lim_q <= limit_i;
    end else if (inc_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign q_o    = cnt_q;
  assign last_o = (cnt_q == lim_q);

  // R6
  lim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |-> !last_o);

endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_ld_pkg::*;
#(
  parameter int unsigned PROG_CYC   = 75,
  parameter int unsigned INIT_TO    = 125_000_000,
  parameter int unsigned SETTLE_CYC = 2_500_000,
  parameter int unsigned BUSY_TO    = 1_250_000,
  parameter int unsigned DONE_TO    = 50_000_000,
  parameter int unsigned CNT_W      = 24,
  parameter bit          BUSY_CHK   = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] total_i,
  input  logic             valid_i,
  input  logic [7:0]       byte_i,
  output logic             ready_o,
  output logic             run_o,
  output logic             ok_o,
  output logic [2:0]       err_o,
  output logic [CNT_W-1:0] sent_o,
  output logic             prog_no,
  input  logic             init_ni,
  input  logic             busy_i,
  input  logic             done_i,
  output logic             cs_no,
  output logic             wr_no,
  output logic             cclk_o,
  output logic [7:0]       data_o
);

  localparam int unsigned T_MAX = max_u(max_u(max_u(INIT_TO, SETTLE_CYC),
                                              max_u(BUSY_TO, DONE_TO)), PROG_CYC);
  localparam int unsigned TW = $clog2(T_MAX + 1);
  localparam logic [TW-1:0] LIM_PROG   = TW'(PROG_CYC - 1);
  localparam logic [TW-1:0] LIM_INIT   = TW'(INIT_TO - 1);
  localparam logic [TW-1:0] LIM_SETTLE = TW'(SETTLE_CYC - 1);
  localparam logic [TW-1:0] LIM_BUSY   = TW'(BUSY_TO - 1);
  localparam logic [TW-1:0] LIM_DONE   = TW'(DONE_TO - 1);

  ld_st_e      st_q, st_d;
  logic [TW-1:0] t_q;
  logic        abort, pass, start_ok, accept, last;
  logic [2:0]  err_code;
  logic        prog_q, wr_q, cs_q, cclk_q, ok_q;
  logic [2:0]  err_q;
  logic [7:0]  data_q;

  assign start_ok = (st_q == ST_IDLE) && start_i;
  assign ready_o  = (st_q == ST_DATA) && !done_i && init_ni && !last;
  assign accept   = ready_o && valid_i;

  cfg_ld_timer #(.W(TW)) u_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (st_d != st_q),
    .q_o   (t_q)
  );

  cfg_ld_bytecnt #(.W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_ok),
    .inc_i  (st_q == ST_HI),
    .limit_i(total_i),
    .q_o    (sent_o),
    .last_o (last)
  );

  always_comb begin
    st_d     = st_q;
    abort    = 1'b0;
    pass     = 1'b0;
    err_code = ERR_NONE;
    unique case (st_q)
      ST_IDLE:   if (start_i) st_d = ST_PROG;
      ST_PROG: begin
        if (!init_ni && t_q >= LIM_PROG) st_d = ST_REL;
        else if (t_q >= LIM_INIT) begin abort = 1'b1; err_code = ERR_INIT_SET; end
      end
      ST_REL: begin
        if (init_ni) st_d = ST_WREN;
        else if (t_q >= LIM_INIT) begin abort = 1'b1; err_code = ERR_INIT_REL; end
      end
      ST_WREN:   st_d = ST_SETTLE;
      ST_SETTLE: if (t_q >= LIM_SETTLE) st_d = ST_DATA;
      ST_DATA: begin
        // done wins over init, init over end of count
        if (done_i)        st_d = ST_FIN;
        else if (!init_ni) begin abort = 1'b1; err_code = ERR_MIDLOAD; end
        else if (last)     st_d = ST_FIN;
        else if (valid_i)  st_d = ST_HI;
      end
      ST_HI:     st_d = BUSY_CHK ? ST_BWAIT : ST_DATA;
      ST_BWAIT: begin
        if (!busy_i) st_d = ST_DATA;
        else if (t_q >= LIM_BUSY) begin abort = 1'b1; err_code = ERR_BUSY; end
      end
      ST_FIN:    st_d = ST_CHK;
      ST_CHK: begin
        if (done_i && init_ni) begin st_d = ST_IDLE; pass = 1'b1; end
        else if (t_q >= LIM_DONE) begin abort = 1'b1; err_code = ERR_DONE; end
      end
      default:   st_d = ST_IDLE;
    endcase
    if (abort) st_d = ST_IDLE;
  end

  // pins registered from next state so they leave flops cleanly
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      prog_q <= 1'b1;
      wr_q   <= 1'b1;
      cs_q   <= 1'b1;
      cclk_q <= 1'b0;
      data_q <= '0;
      ok_q   <= 1'b0;
      err_q  <= ERR_NONE;
    end else begin
      st_q   <= st_d;
      prog_q <= (st_d != ST_PROG);
      wr_q   <= !(st_d inside {ST_WREN, ST_SETTLE, ST_DATA, ST_HI, ST_BWAIT, ST_FIN});
      cs_q   <= !(st_d inside {ST_SETTLE, ST_DATA, ST_HI, ST_BWAIT});
      cclk_q <= !(st_d inside {ST_IDLE, ST_PROG, ST_HI});
      if (accept) data_q <= byte_i;
      if (start_ok) begin
        ok_q  <= 1'b0;
        err_q <= ERR_NONE;
      end
      if (pass)  ok_q  <= 1'b1;
      if (abort) err_q <= err_code;
    end
  end

  assign run_o   = (st_q != ST_IDLE);
  assign ok_o    = ok_q;
  assign err_o   = err_q;
  assign prog_no = prog_q;
  assign wr_no   = wr_q;
  assign cs_no   = cs_q;
  assign cclk_o  = cclk_q;
  assign data_o  = data_q;

  // R2
  prog_init_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(prog_no) && err_o == ERR_NONE) |-> $past(!init_ni));

  // R5
  wr_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |-> !wr_no);

  // R6
  accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && valid_i) |=> (!cclk_o && data_o == $past(byte_i)));

  // R6
  cclk_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cclk_o) && run_o) |=> cclk_o);

  // R7
  ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (!cs_no && !wr_no && prog_no && cclk_o));

  // R11
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_no) |-> cs_no);

  // R12
  ok_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ok_o && err_o != ERR_NONE));

  // R13
  idle_pins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_o |-> (cs_no && wr_no && prog_no));

endmodule

// File: tb/cfg_loader_test.sv
module cfg_loader_test;

  localparam int PROG_CYC = 4;
  localparam int INIT_TO  = 24;
  localparam int SETTLE   = 6;
  localparam int BUSY_TO  = 10;
  localparam int DONE_TO  = 20;
  localparam int CW       = 8;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, valid_i = 1'b0;
  logic [CW-1:0] total_i = '0;
  logic [7:0] byte_i;
  logic ready_o, run_o, ok_o, prog_no, cs_no, wr_no, cclk_o;
  logic [2:0] err_o;
  logic [CW-1:0] sent_o;
  logic [7:0] data_o;
  logic init_ni = 1'b1, busy_i = 1'b0, done_i = 1'b0;

  always #2 clk_i = ~clk_i;

  cfg_loader #(
    .PROG_CYC(PROG_CYC), .INIT_TO(INIT_TO), .SETTLE_CYC(SETTLE),
    .BUSY_TO(BUSY_TO), .DONE_TO(DONE_TO), .CNT_W(CW), .BUSY_CHK(1'b1)
  ) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .total_i(total_i),
    .valid_i(valid_i), .byte_i(byte_i), .ready_o(ready_o), .run_o(run_o),
    .ok_o(ok_o), .err_o(err_o), .sent_o(sent_o), .prog_no(prog_no),
    .init_ni(init_ni), .busy_i(busy_i), .done_i(done_i), .cs_no(cs_no),
    .wr_no(wr_no), .cclk_o(cclk_o), .data_o(data_o)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;

  function automatic logic [7:0] pat8(input int n);
    return 8'((n * 29 + 7) ^ (n >> 3));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // stream source
  int acc = 0, base = 0;
  assign byte_i = pat8(acc);
  always @(posedge clk_i) if (ready_o && valid_i) acc <= acc + 1;

  // target model knobs and state
  int k_idly, k_rdly, k_crc, k_done, k_busy, k_ddly;
  int pc, rc, fc, bc, nrx, rx_bad, pw, rdy_bad, cs_pre, wr_pre;
  bit armed, rel_done, saw_ready, saw_wr, ord_a, ord_ok;
  logic p_cclk = 1'b0, p_cs = 1'b1, p_wr = 1'b1;

  always @(negedge clk_i) begin
    valid_i = ($urandom_range(0, 3) != 0);
    if (ready_o) saw_ready = 1'b1;
    if (ready_o && (cs_no || wr_no)) rdy_bad++;
    if (!cs_no && !saw_ready) cs_pre++;
    if (!wr_no && cs_no && !saw_ready) wr_pre++;
    if (!wr_no) saw_wr = 1'b1;
    if (!p_cs && cs_no && !wr_no) ord_a = 1'b1;
    if (!p_wr && wr_no && p_cs && ord_a) ord_ok = 1'b1;
    if (!prog_no) begin
      pc++; pw++; armed = 1'b1;
      if (pc > k_idly) init_ni = 1'b0;
    end else if (armed) begin
      if (!rel_done) begin
        rc++;
        if (rc > k_rdly) begin init_ni = 1'b1; rel_done = 1'b1; end
      end
      if (cclk_o && !p_cclk && !cs_no && !wr_no) begin
        if (data_o != pat8(base + nrx)) rx_bad++;
        nrx++;
        if (nrx == k_crc) init_ni = 1'b0;
        if (nrx == k_done) done_i = 1'b1;
        bc = k_busy;
      end else if (bc > 0) bc--;
      busy_i = (bc > 0);
      if (saw_wr && wr_no && cs_no) begin
        fc++;
        if (fc > k_ddly) done_i = 1'b1;
      end
    end
    p_cclk = cclk_o; p_cs = cs_no; p_wr = wr_no;
  end

  task automatic run_case(input int tot, input int idly, input int rdly, input int crc,
                          input int dn, input int bsy, input int ddly);
    int e_err, e_sent, e_pw, lim, w;
    bit e_data;
    string tag;
    @(negedge clk_i);
    k_idly = idly; k_rdly = rdly; k_crc = crc; k_done = dn; k_busy = bsy; k_ddly = ddly;
    pc = 0; rc = 0; fc = 0; bc = 0; nrx = 0; rx_bad = 0; pw = 0; rdy_bad = 0;
    cs_pre = 0; wr_pre = 0; armed = 0; rel_done = 0; saw_ready = 0; saw_wr = 0;
    ord_a = 0; ord_ok = 0; init_ni = 1'b1; done_i = 1'b0; busy_i = 1'b0;
    base = acc;
    total_i = CW'(tot); start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    w = 0;
    while (run_o && w < 3000) begin @(negedge clk_i); w++; end
    chk(w < 3000, "R13", w, 3000);
    // expected outcome
    e_err = 0; e_sent = 0; e_data = 0;
    if (idly >= INIT_TO) begin e_err = 1; e_pw = INIT_TO; end
    else begin
      e_pw = (idly + 1 > PROG_CYC) ? idly + 1 : PROG_CYC;
      if (rdly >= INIT_TO) e_err = 2;
      else begin
        e_data = 1; lim = tot;
        if (dn > 0 && dn < lim) lim = dn;
        if (bsy >= BUSY_TO && lim >= 1) begin e_err = 4; e_sent = 1; end
        else if (crc > 0 && crc <= lim) begin e_err = 3; e_sent = crc; end
        else begin
          e_sent = lim;
          if (!(dn > 0 && dn <= tot) && ddly >= DONE_TO) e_err = 5;
        end
      end
    end
    case (e_err)
      1: tag = "R3";
      2: tag = "R4";
      3: tag = "R9";
      4: tag = "R10";
      default: tag = "R12";
    endcase
    chk(err_o == 3'(e_err), tag, err_o, e_err);
    chk(ok_o == (e_err == 0), "R12", ok_o, e_err == 0);
    chk(nrx == e_sent, "R8", nrx, e_sent);
    chk(sent_o == CW'(e_sent), "R9", sent_o, e_sent);
    chk(rx_bad == 0, "R6", rx_bad, 0);
    chk(rdy_bad == 0, "R7", rdy_bad, 0);
    chk(pw == e_pw, "R2", pw, e_pw);
    chk(prog_no && cs_no && wr_no && !run_o, "R13",
        {prog_no, cs_no, wr_no, run_o}, 4'b1110);
    if (e_data && tot > 0) begin
      chk(cs_pre == SETTLE, "R5", cs_pre, SETTLE);
      chk(wr_pre == 1, "R5", wr_pre, 1);
    end
    if (e_err == 0 || e_err == 5) chk(ord_ok, "R11", ord_ok, 1);
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk_i);
    // R1
    chk(prog_no && cs_no && wr_no && !cclk_o && !ready_o && !run_o && !ok_o && err_o == 0,
        "R1", {prog_no, cs_no, wr_no, cclk_o, ready_o, run_o, ok_o}, 7'b1110000);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(prog_no && cs_no && wr_no && !run_o, "R1", {prog_no, cs_no, wr_no, run_o}, 4'b1110);
    // directed corners
    run_case(8, 2, 3, 0, 0, 0, 2);                  // basic
    run_case(5, 0, 0, 0, 0, 0, 0);                  // R2 minimum width
    run_case(3, INIT_TO - 1, 1, 0, 0, 1, 1);        // R2 last legal cycle
    run_case(3, INIT_TO, 1, 0, 0, 0, 1);            // R3
    run_case(3, 1, INIT_TO - 1, 0, 0, 0, 1);        // R4 edge pass
    run_case(3, 1, INIT_TO, 0, 0, 0, 1);            // R4
    run_case(10, 1, 1, 3, 0, 1, 1);                 // R9
    run_case(6, 1, 1, 6, 0, 0, 1);                  // R9 on last byte
    run_case(10, 1, 1, 0, 4, 0, DONE_TO);           // R8 early done
    run_case(3, 1, 1, 0, 0, BUSY_TO - 1, 1);        // R10 edge pass
    run_case(3, 1, 1, 0, 0, BUSY_TO, 1);            // R10
    run_case(4, 1, 1, 0, 0, 0, DONE_TO - 1);        // R12 edge pass
    run_case(4, 1, 1, 0, 0, 0, DONE_TO);            // R12 timeout
    run_case(0, 1, 1, 0, 0, 0, 1);                  // empty load
    // random loads
    for (int i = 0; i < 30; i++) begin
      int tot, mode, crc, dn;
      tot = $urandom_range(1, 24);
      mode = $urandom_range(0, 2);
      crc = (mode == 1) ? $urandom_range(1, tot) : 0;
      dn  = (mode == 2) ? $urandom_range(1, tot) : 0;
      run_case(tot, $urandom_range(0, INIT_TO), $urandom_range(0, INIT_TO), crc, dn,
               $urandom_range(0, BUSY_TO), $urandom_range(0, DONE_TO));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule